// File: doc/BRIEF.md
# Interrupt Request Set/Clear Controller

This block gathers seven event sources into one interrupt flag register and drives a single interrupt pin. The sources are a timer expiry, an error condition, low and high fill alerts, command completion (idle), receive done and transmit done. Single-cycle event pulses latch into sticky flags. A host bus writes the flag register with set/clear semantics and writes a separate enable register. That enable register decides which flags reach the combined request and whether the pin is inverted.

The idle source comes from a small command tracker with two states, `CMD_IDLE` and `CMD_BUSY`. Its transitions are:
- **START**: `CMD_IDLE` to `CMD_BUSY` on a known, non-idle command write.
- **REJECT**: stays in `CMD_IDLE` on an unknown command write, and raises the idle event.
- **FINISH**: `CMD_BUSY` to `CMD_IDLE` on `cmd_done`, and raises the idle event.
- **ABORT**: `CMD_BUSY` to `CMD_IDLE` when the host writes the idle command. No event is raised.
- **RESTART**: stays in `CMD_BUSY` on a known command write.
- **FALLBACK**: `CMD_BUSY` to `CMD_IDLE` on an unknown command write, and raises the idle event.

A command write takes priority over `cmd_done` in the same cycle.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: Flag bit positions are fixed: timer=0, error=1, low alert=2, high alert=3, idle=4, receive=5, transmit=6. A one-cycle pulse on a source sets its flag on the next clock edge, and the flag stays set after the pulse ends.
- R2: A flag-register write (`host_wr`=1, `host_sel`=0) with `host_wdata[7]`=1 sets every flag whose data bit is 1. With `host_wdata[7]`=0 it clears every flag whose data bit is 1. Flags written with 0 keep their value.
- R3: Writing 0x7F to the flag register clears all seven flags.
- R4: After reset `flag_rdata` is 0x14, `enable_rdata` is 0x80, `cmd_busy` is 0 and `irq_pin` is 1.
- R5: Enable bits 0..6 map to the same sources as the flag bits. A flag whose enable bit is 0 does not contribute to the request.
- R6: When enable bit 7 is 1, `irq_pin` is the inverse of the combined request. When it is 0, `irq_pin` equals the request.
- R7: The error flag sets in any cycle in which any bit of `err_status` is 1.
- R8: The idle flag sets on FINISH, REJECT and FALLBACK. It does not set on ABORT. `cmd_busy` is 1 exactly in `CMD_BUSY`.
- R9: A source event in the same cycle as a host clear of that flag wins, and the flag stays set.
- R10: The combined request is registered, so `irq_pin` reflects a flag change one clock after the flag changes.
- R11: An enable-register write (`host_wr`=1, `host_sel`=1) loads all eight bits, and `enable_rdata` reads them back. Bit 7 of `flag_rdata` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Write target: 0 = flag register, 1 = enable register |
| host_wdata | input | 8 | Host write data |
| flag_rdata | output | 8 | Flag register readback (bit 7 reads 0) |
| enable_rdata | output | 8 | Enable register readback |
| evt_timer | input | 1 | Timer expiry pulse |
| evt_lo_alert | input | 1 | Low alert pulse |
| evt_hi_alert | input | 1 | High alert pulse |
| evt_rx | input | 1 | Receive-done pulse |
| evt_tx | input | 1 | Transmit-done pulse |
| err_status | input | ERR_W | Error status vector; any 1 sets the error flag |
| cmd_wr | input | 1 | Command write strobe |
| cmd_idle | input | 1 | The written command is the idle command |
| cmd_known | input | 1 | The written command code is recognised |
| cmd_done | input | 1 | The running command has finished |
| cmd_busy | output | 1 | Command tracker is in CMD_BUSY |
| irq_pin | output | 1 | Interrupt output after masking and polarity |

## Verification
Two situations are hard to reach from the ports.

- **Event against host clear.** A source pulse must land in exactly the same cycle as a host clear of that flag. The bench has one driver task that puts the event and the clear write on the same clock edge.
- **ABORT against FINISH.** The two must be told apart. The bench starts a command, then writes the idle command before any `cmd_done`, and checks that the idle flag stays clear. It then completes a command normally and checks that the idle flag sets.

The one-cycle request latency is checked by sampling `irq_pin` both before and after the registered request updates.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int IRQ_SRC = 7;
    localparam int REG_W   = 8;

    typedef enum logic [2:0] {
        SRC_TIMER = 3'd0,
        SRC_ERR   = 3'd1,
        SRC_LO    = 3'd2,
        SRC_HI    = 3'd3,
        SRC_IDLE  = 3'd4,
        SRC_RX    = 3'd5,
        SRC_TX    = 3'd6
    } irq_src_e;

    typedef enum logic {
        CMD_IDLE = 1'b0,
        CMD_BUSY = 1'b1
    } cmd_state_e;

    localparam logic [REG_W-1:0] FLAG_RST = 8'h14;
    localparam logic [REG_W-1:0] EN_RST   = 8'h80;

endpackage

// File: rtl/irq_cmd_tracker.sv
module irq_cmd_tracker
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_idle,
    input  logic cmd_known,
    input  logic cmd_done,
    output logic busy,
    output logic idle_evt
);

    cmd_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    // next state and event output
    always_comb begin
        state_d  = state_q;
        idle_evt = 1'b0;
        unique case (state_q)
            CMD_IDLE: begin
                if (cmd_wr && !cmd_idle) begin
                    if (cmd_known) begin
                        state_d = CMD_BUSY;        // START
                    end else begin
                        idle_evt = 1'b1;           // REJECT
                    end
                end
            end
            CMD_BUSY: begin
                if (cmd_wr) begin
                    if (cmd_idle) begin
                        state_d = CMD_IDLE;        // ABORT
                    end else if (!cmd_known) begin
                        state_d  = CMD_IDLE;       // FALLBACK
                        idle_evt = 1'b1;
                    end else begin
                        state_d = CMD_BUSY;        // RESTART
                    end
                end else if (cmd_done) begin
                    state_d  = CMD_IDLE;           // FINISH
                    idle_evt = 1'b1;
                end
            end
            default: state_d = CMD_IDLE;
        endcase
    end

    assign busy = (state_q == CMD_BUSY);

    // R8
    host_idle_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_idle) |-> !idle_evt);

    // R8
    finish_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_done && !cmd_wr) |=> !busy);

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_idle && cmd_known) |=> busy);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int N = IRQ_SRC,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_flags,
    input  logic [W-1:0] wdata,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flags
);

    localparam int SEL_BIT = W - 1;

    logic set_mode;
    assign set_mode = wdata[SEL_BIT];

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                  flags[i] <= FLAG_RST[i];
            else if (evt[i])             flags[i] <= 1'b1;
            else if (wr_flags && wdata[i]) flags[i] <= set_mode;
        end

        // R2
        set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flags && wdata[i] && wdata[SEL_BIT]) |=> flags[i]);

        // R2
        clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flags && wdata[i] && !wdata[SEL_BIT] && !evt[i]) |=> !flags[i]);

        // R2
        unmarked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[i] && !(wr_flags && wdata[i])) |=> $stable(flags[i]));

        // R9
        event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flags[i]);
    end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
    import irq_pkg::*;
#(
    parameter int N = IRQ_SRC,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [N-1:0] flags,
    output logic [W-1:0] en_q,
    output logic         req_q,
    output logic         pin
);

    localparam int INV_BIT = W - 1;

    logic [N-1:0] masked;
    assign masked = flags & en_q[N-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= EN_RST;
        else if (wr_en) en_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |masked;
    end

    assign pin = en_q[INV_BIT] ? ~req_q : req_q;

    // R11
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wdata)));

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & en_q[N-1:0]) == '0) |=> !req_q);

    // R10
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & en_q[N-1:0]) != '0) |=> req_q);

endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
    import irq_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_sel,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       flag_rdata,
    output logic [7:0]       enable_rdata,
    input  logic             evt_timer,
    input  logic             evt_lo_alert,
    input  logic             evt_hi_alert,
    input  logic             evt_rx,
    input  logic             evt_tx,
    input  logic [ERR_W-1:0] err_status,
    input  logic             cmd_wr,
    input  logic             cmd_idle,
    input  logic             cmd_known,
    input  logic             cmd_done,
    output logic             cmd_busy,
    output logic             irq_pin
);

    logic [IRQ_SRC-1:0] evt_vec;
    logic [IRQ_SRC-1:0] flags;
    logic               idle_evt;
    logic               req_q;

    always_comb begin
        evt_vec           = '0;
        evt_vec[SRC_TIMER] = evt_timer;
        evt_vec[SRC_ERR]   = |err_status;
        evt_vec[SRC_LO]    = evt_lo_alert;
        evt_vec[SRC_HI]    = evt_hi_alert;
        evt_vec[SRC_IDLE]  = idle_evt;
        evt_vec[SRC_RX]    = evt_rx;
        evt_vec[SRC_TX]    = evt_tx;
    end

    irq_cmd_tracker u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_idle (cmd_idle),
        .cmd_known(cmd_known),
        .cmd_done (cmd_done),
        .busy     (cmd_busy),
        .idle_evt (idle_evt)
    );

    irq_flag_bank #(.N(IRQ_SRC), .W(REG_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_flags(host_wr && !host_sel),
        .wdata   (host_wdata),
        .evt     (evt_vec),
        .flags   (flags)
    );

    irq_req_gen #(.N(IRQ_SRC), .W(REG_W)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (host_wr && host_sel),
        .wdata (host_wdata),
        .flags (flags),
        .en_q  (enable_rdata),
        .req_q (req_q),
        .pin   (irq_pin)
    );

    assign flag_rdata = {1'b0, flags};

    // R7
    err_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status != '0) |=> flag_rdata[SRC_ERR]);

    // R11
    flag_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_rdata[7]);

    // R6
    quiet_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_q && enable_rdata[7]) |-> irq_pin);

endmodule

// File: tb/sim_irq_setclr_ctrl.sv
`timescale 1ns/1ps
module sim_irq_setclr_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_sel = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] flag_rdata, enable_rdata;
    logic evt_timer = 0, evt_lo_alert = 0, evt_hi_alert = 0, evt_rx = 0, evt_tx = 0;
    logic [7:0] err_status = '0;
    logic cmd_wr = 0, cmd_idle = 0, cmd_known = 0, cmd_done = 0;
    logic cmd_busy, irq_pin;

    always #2.5 clk = ~clk;

    irq_setclr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .flag_rdata(flag_rdata), .enable_rdata(enable_rdata),
        .evt_timer(evt_timer), .evt_lo_alert(evt_lo_alert), .evt_hi_alert(evt_hi_alert),
        .evt_rx(evt_rx), .evt_tx(evt_tx), .err_status(err_status),
        .cmd_wr(cmd_wr), .cmd_idle(cmd_idle), .cmd_known(cmd_known), .cmd_done(cmd_done),
        .cmd_busy(cmd_busy), .irq_pin(irq_pin)
    );

    typedef struct {
        string      tag;
        bit         cf;
        logic [7:0] fl;
        logic [7:0] en;
        bit         cp;
        logic       pin;
        bit         cb;
        logic       busy;
    } sb_item_t;

    sb_item_t sbq[$];
    int checks = 0;
    int errors = 0;

    logic [7:0] m_flags = 8'h14;
    logic [7:0] m_en    = 8'h80;
    logic       m_busy  = 1'b0;

    function automatic logic model_pin();
        return (|(m_flags[6:0] & m_en[6:0])) ^ m_en[7];
    endfunction

    // monitor: compares every queued item shortly after the falling edge
    always @(negedge clk) begin
        #1;
        while (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            if (it.cf) begin
                checks++;
                if (flag_rdata !== it.fl || enable_rdata !== it.en) begin
                    errors++;
                    $display("FAIL %s: flags=%h en=%h expected flags=%h en=%h",
                             it.tag, flag_rdata, enable_rdata, it.fl, it.en);
                end
            end
            if (it.cp) begin
                checks++;
                if (irq_pin !== it.pin) begin
                    errors++;
                    $display("FAIL %s: irq_pin=%b expected %b", it.tag, irq_pin, it.pin);
                end
            end
            if (it.cb) begin
                checks++;
                if (cmd_busy !== it.busy) begin
                    errors++;
                    $display("FAIL %s: cmd_busy=%b expected %b", it.tag, cmd_busy, it.busy);
                end
            end
        end
    end

    // push the model state after one settling cycle
    task automatic expect_all(string tag);
        sb_item_t it;
        @(negedge clk);
        it.tag = tag; it.cf = 1; it.fl = m_flags; it.en = m_en;
        it.cp = 1; it.pin = model_pin(); it.cb = 1; it.busy = m_busy;
        sbq.push_back(it);
    endtask

    task automatic expect_pin_now(string tag, logic p);
        sb_item_t it;
        it.tag = tag; it.cf = 0; it.fl = '0; it.en = '0;
        it.cp = 1; it.pin = p; it.cb = 0; it.busy = 0;
        sbq.push_back(it);
    endtask

    // one cycle of host write and/or events; ev index follows flag positions
    task automatic drive(bit w, bit sel, logic [7:0] d, logic [6:0] ev, logic [7:0] err);
        @(negedge clk);
        host_wr = w; host_sel = sel; host_wdata = d;
        evt_timer = ev[0]; evt_lo_alert = ev[2]; evt_hi_alert = ev[3];
        evt_rx = ev[5]; evt_tx = ev[6]; err_status = err;
        @(negedge clk);
        host_wr = 0; host_sel = 0; host_wdata = '0;
        evt_timer = 0; evt_lo_alert = 0; evt_hi_alert = 0; evt_rx = 0; evt_tx = 0;
        err_status = '0;
        if (w && sel) m_en = d;
        else if (w) begin
            for (int i = 0; i < 7; i++) if (d[i]) m_flags[i] = d[7];
        end
        for (int i = 0; i < 7; i++) if (ev[i]) m_flags[i] = 1'b1;
        if (err != '0) m_flags[1] = 1'b1;
    endtask

    task automatic cmd(bit w, bit idl, bit known, bit done);
        @(negedge clk);
        cmd_wr = w; cmd_idle = idl; cmd_known = known; cmd_done = done;
        @(negedge clk);
        cmd_wr = 0; cmd_idle = 0; cmd_known = 0; cmd_done = 0;
        if (!m_busy) begin
            if (w && !idl) begin
                if (known) m_busy = 1; else m_flags[4] = 1;
            end
        end else begin
            if (w) begin
                if (idl) m_busy = 0;
                else if (!known) begin m_busy = 0; m_flags[4] = 1; end
            end else if (done) begin
                m_busy = 0; m_flags[4] = 1;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic old_pin;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_all("R4 reset values");

        drive(1, 0, 8'h7F, 7'h00, 8'h00); expect_all("R3 clear all");
        drive(1, 0, 8'h85, 7'h00, 8'h00); expect_all("R2 set marked bits");
        drive(1, 0, 8'h04, 7'h00, 8'h00); expect_all("R2 clear marked, others kept");
        drive(1, 1, 8'h01, 7'h00, 8'h00); expect_all("R11 R6 non-inverted pin high");
        drive(1, 1, 8'h81, 7'h00, 8'h00); expect_all("R6 inverted pin low");
        drive(1, 1, 8'h02, 7'h00, 8'h00); expect_all("R5 timer masked");

        // R10: error flag set, pin follows one clock later
        old_pin = model_pin();
        drive(0, 0, 8'h00, 7'h00, 8'h10);
        expect_pin_now("R10 pin before request update", old_pin);
        expect_all("R7 R10 error flag and pin");
        drive(0, 0, 8'h00, 7'h00, 8'h80); expect_all("R7 top status bit");

        drive(1, 0, 8'h7F, 7'h00, 8'h00); expect_all("R3 clear again");
        drive(1, 0, 8'h20, 7'h20, 8'h00); expect_all("R9 event beats clear");
        drive(0, 0, 8'h00, 7'h40, 8'h00); expect_all("R1 transmit bit 6");
        drive(0, 0, 8'h00, 7'h08, 8'h00); expect_all("R1 high alert bit 3");
        drive(0, 0, 8'h00, 7'h04, 8'h00); expect_all("R1 low alert bit 2");
        drive(0, 0, 8'h00, 7'h01, 8'h00); expect_all("R1 timer bit 0");
        drive(1, 0, 8'h7F, 7'h00, 8'h00);
        drive(1, 1, 8'h10, 7'h00, 8'h00); expect_all("R5 idle enabled, flags clear");

        cmd(1, 0, 1, 0); expect_all("R8 start busy");
        cmd(0, 0, 0, 1); expect_all("R8 finish sets idle");
        drive(1, 0, 8'h10, 7'h00, 8'h00);
        cmd(1, 0, 1, 0);
        cmd(1, 1, 0, 0); expect_all("R8 host idle write no flag");
        cmd(1, 0, 0, 0); expect_all("R8 unknown command sets idle");
        drive(1, 0, 8'h10, 7'h00, 8'h00);
        cmd(1, 0, 1, 0);
        cmd(1, 0, 0, 0); expect_all("R8 fallback from busy");
        drive(1, 0, 8'hFF, 7'h00, 8'h00); expect_all("R2 R11 set all, bit7 reads 0");

        @(negedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule